// File: doc/BRIEF.md
# MDIO Management Master with Register Control

This block is a serial management master for Ethernet PHYs. A host controls it through two 32-bit registers on a simple write/read port. A write to the command register with its launch bit set sends one complete management frame on MDC/MDIO. The block produces the MDC clock and shifts the frame out. On read frames it releases the data line and collects 16 bits returned by the PHY.

The command word chooses between Clause 22 and Clause 45 framing. It also carries the opcode, port address, register or device address and the 16-bit payload. The configuration/status register holds three settings: the MDC half-period, the sampling edge, and a capture delay counted in system clocks. The same register reports an idle flag and the last read result. While a frame runs, the launch bit reads back as 1. Hardware clears it when the frame is over. Any register write made during a frame is discarded.

Top module: `mdio_master`

## Requirements
- R1: After reset the command register reads 0x00000000. The configuration/status register reads 0x04010000: divider 4, rising-edge sampling, no delay, idle set. MDC is low and MDIO is not driven (output enable low).
- R2: A write of the command register (byte address 0x0) with bit 31 set, made while idle, launches a frame on the clock edge that registers the write. While the frame runs, command bit 31 reads 1 and status bit 16 (idle) reads 0. When the frame ends, both return to 0 and 1 by themselves.
- R3: The divider field is status bits 31:24, holding value T. MDC stays low for T+1 clocks after launch, then toggles every T+1 clocks for 64 bit periods, and ends low.
- R4: The 64 frame bits are sent most significant bit first, and each bit is launched when MDC falls. The order is: 32 ones; start 01 (command bit 28 = 1, Clause 22) or 00 (bit 28 = 0, Clause 45); opcode = bits 27:26; port = bits 25:21; register/device = bits 20:16; two turnaround bits; 16 data bits.
- R5: Frames that are not reads keep output enable high for all 64 bits. The turnaround is 1 then 0, and the data bits are command bits 15:0.
- R6: Read frames are Clause 22 opcode 10, or Clause 45 opcode 10 or 11. On these, output enable drops at the first turnaround bit and stays low to the end. The 16 sampled bits land in status bits 15:0, first sample in bit 15.
- R7: Status bit 23 selects the sampling edge: 0 samples at MDC rising, 1 at MDC falling. Status bits 22:20 (L) delay each capture by L clocks after that edge, and L must stay below the MDC period. The frame ends at the last falling MDC edge or at the last capture, whichever comes later.
- R8: While a frame is in progress, writes to either register have no effect on the frame, on the stored command or on the stored configuration.
- R9: The configuration/status register (byte address 0x4) reads back as divider[31:24], edge[23], delay[22:20], zeros[19:17], idle[16], read data[15:0]. The command register reads back as busy[31], zeros[30:29], and the stored bits 28:0.
- R10: A command write with bit 31 clear, made while idle, updates the stored fields but starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte address: 0x0 command, 0x4 configuration/status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 drives the line) |

## Verification
Several properties are checked on every cycle: the line stays quiet while idle, MDC changes only after a full divider count, the bit index advances only on a falling MDC, frames start only from a host write, stored registers hold through writes made mid-frame, and captures never overlap. Other behaviour only the bench scenarios can show. That includes the exact bit content and order of each frame type, the release window on reads, and the value assembled from samples taken at the chosen edge and delay. It also covers the stretch of the frame end when a delayed capture finishes late, and the register readback after ignored writes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int BODY_BITS = 32;

  typedef struct packed {
    logic        c22;
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  dreg;
    logic [15:0] payload;
  } mdio_cmd_t;

  function automatic logic is_read(mdio_cmd_t c);
    if (c.c22) return (c.op == 2'b10);
    return c.op[1];
  endfunction

  // Everything after the preamble: start, opcode, addresses, turnaround, data.
  function automatic logic [BODY_BITS-1:0] frame_body(mdio_cmd_t c);
    logic [1:0]  st;
    logic [1:0]  ta;
    logic [15:0] dat;
    st  = c.c22 ? 2'b01 : 2'b00;
    ta  = is_read(c) ? 2'b11 : 2'b10;
    dat = is_read(c) ? 16'h0000 : c.payload;
    return {st, c.op, c.port, c.dreg, ta, dat};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [THR_W-1:0] thr,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [THR_W-1:0] div_q, div_d;
  logic             mdc_q, mdc_d;
  logic             hit;

  assign hit      = run && (div_q == thr);
  assign rise_evt = hit && !mdc_q;
  assign fall_evt = hit && mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    div_d = div_q;
    mdc_d = mdc_q;
    if (!run) begin
      div_d = '0;
      mdc_d = 1'b0;
    end else if (hit) begin
      div_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      div_q <= div_d;
      mdc_q <= mdc_d;
    end
  end

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q != $past(mdc_q)) |-> $past(div_q == thr)); // R3

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int LEN     = PRE_LEN + BODY_BITS,
  parameter int IDX_W   = $clog2(LEN)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      launch,
  input  mdio_cmd_t cmd_in,
  input  logic      fall_evt,
  output logic      active,
  output logic      last_fall,
  output logic      data_phase,
  output logic      mdio_o,
  output logic      mdio_oe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_LEN + 16);

  logic [LEN-1:0]   frame_q, frame_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             act_q, act_d;
  logic             rd_q, rd_d;
  logic             released;

  assign active     = act_q;
  assign last_fall  = act_q && fall_evt && (idx_q == LAST_IDX);
  assign data_phase = act_q && rd_q && (idx_q >= DATA_IDX);
  assign released   = rd_q && (idx_q >= TA_IDX);
  assign mdio_oe    = act_q && !released;
  assign mdio_o     = mdio_oe && frame_q[LAST_IDX - idx_q];

  always_comb begin
    frame_d = frame_q;
    idx_d   = idx_q;
    act_d   = act_q;
    rd_d    = rd_q;
    if (launch) begin
      frame_d = {{PRE_LEN{1'b1}}, frame_body(cmd_in)};
      rd_d    = is_read(cmd_in);
      idx_d   = '0;
      act_d   = 1'b1;
    end else if (act_q && fall_evt) begin
      if (idx_q == LAST_IDX) act_d = 1'b0;
      else                   idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx_q   <= '0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      frame_q <= frame_d;
      idx_q   <= idx_d;
      act_q   <= act_d;
      rd_q    <= rd_d;
    end
  end

  AST_BIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && (idx_q != $past(idx_q))) |-> $past(fall_evt)); // R4

endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
  parameter int LAT_W = 3,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [LAT_W-1:0] lat,
  input  logic             mdio_i,
  output logic [DW-1:0]    rd_data,
  output logic             pend_nxt
);

  logic [DW-1:0]    sh_q, sh_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             take;

  assign take     = (evt && (lat == '0)) || (pend_q && (cnt_q == '0));
  assign rd_data  = sh_q;
  assign pend_nxt = pend_d;

  always_comb begin
    sh_d   = take ? {sh_q[DW-2:0], mdio_i} : sh_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (evt && (lat != '0)) begin
      pend_d = 1'b1;
      cnt_d  = lat - 1'b1;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  AST_NO_CAPTURE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (!pend_q || (cnt_q == '0))); // R7

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         ADDR_W  = 3,
  parameter int         PRE_LEN = 32,
  parameter logic [7:0] RST_THR = 8'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int THR_W = 8;
  localparam int LAT_W = 3;
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(4);

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  mdio_cmd_t        cmd_q, cmd_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             edge_q, edge_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             busy_q, busy_d;

  logic cmd_we, cfg_we, launch;
  logic active, last_fall, data_phase;
  logic rise_evt, fall_evt, cap_evt, pend_nxt;
  logic [15:0] rd_data;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[30:29];
  assign cmd_we  = bus_wr_en && (bus_addr == CMD_ADDR) && !busy_q;
  assign cfg_we  = bus_wr_en && (bus_addr == CFG_ADDR) && !busy_q;
  assign launch  = cmd_we && bus_wdata[31];
  assign cap_evt = data_phase && (edge_q ? fall_evt : rise_evt);

  always_comb begin
    cmd_d  = cmd_q;
    thr_d  = thr_q;
    edge_d = edge_q;
    lat_d  = lat_q;
    busy_d = busy_q;
    if (cmd_we) cmd_d = mdio_cmd_t'(bus_wdata[28:0]);
    if (cfg_we) begin
      thr_d  = bus_wdata[31:24];
      edge_d = bus_wdata[23];
      lat_d  = bus_wdata[22:20];
    end
    if (launch)
      busy_d = 1'b1;
    else if (busy_q && (last_fall || !active) && !pend_nxt)
      busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      thr_q  <= RST_THR;
      edge_q <= 1'b0;
      lat_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      thr_q  <= thr_d;
      edge_q <= edge_d;
      lat_q  <= lat_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CMD_ADDR)
      bus_rdata = {busy_q, 2'b00, cmd_q};
    else if (bus_addr == CFG_ADDR)
      bus_rdata = {thr_q, edge_q, lat_q, 3'b000, ~busy_q, rd_data};
  end

  mdio_clkgen #(.THR_W(THR_W)) i_clkgen (
    .clk      (clk),
    .rst_n    (rst_ni),
    .run      (active),
    .thr      (thr_q),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_seq #(.PRE_LEN(PRE_LEN)) i_seq (
    .clk        (clk),
    .rst_n      (rst_ni),
    .launch     (launch),
    .cmd_in     (cmd_d),
    .fall_evt   (fall_evt),
    .active     (active),
    .last_fall  (last_fall),
    .data_phase (data_phase),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  mdio_capture #(.LAT_W(LAT_W), .DW(16)) i_capture (
    .clk      (clk),
    .rst_n    (rst_ni),
    .evt      (cap_evt),
    .lat      (lat_q),
    .mdio_i   (mdio_i),
    .rd_data  (rd_data),
    .pend_nxt (pend_nxt)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_q |-> (!mdc && !mdio_oe)); // R1

  AST_START_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && !$past(busy_q)) |-> $past(bus_wr_en)); // R2

  AST_BUSY_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && bus_wr_en) |=> ($stable(cmd_q) && $stable(thr_q) && $stable(edge_q) && $stable(lat_q))); // R8

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        mdio_i;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int thr_cfg, edge_cfg, lat_cfg;

  always #10 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_tb();
  end

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_addr = 3'd0;
  endtask

  task automatic set_cfg(input int thr, input int edg, input int lat);
    wr_reg(3'd4, {8'(thr), 1'(edg), 3'(lat), 20'h0});
    thr_cfg = thr; edge_cfg = edg; lat_cfg = lat;
  endtask

  function automatic bit pat(input int k, input int s);
    int v;
    v = k ^ (k >> 3) ^ s;
    return v[0];
  endfunction

  function automatic bit fbit(input logic [31:0] c, input int b, input bit rd);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return c[28];
    if (b == 34) return c[27];
    if (b == 35) return c[26];
    if (b <= 40) return c[25 - (b - 36)];
    if (b <= 45) return c[20 - (b - 41)];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    if (rd) return 1'b0;
    return c[15 - (b - 48)];
  endfunction

  function automatic bit is_cap(input int e, input int h);
    for (int j = 0; j < 16; j++) begin
      int b;
      int ce;
      b  = 48 + j;
      ce = (edge_cfg != 0) ? (2 * b + 2) * h + lat_cfg : (2 * b + 1) * h + lat_cfg;
      if (e == ce) return 1'b1;
    end
    return 1'b0;
  endfunction

  // Launches one frame and compares the line, the clock and the busy bit on every cycle.
  task automatic run_frame(input logic [31:0] cmd, input int seed, input bit poke);
    int h, end_e, last_cap;
    bit rd;
    logic samples[$];
    logic [15:0] exp_rd;
    logic [31:0] v;
    h  = thr_cfg + 1;
    rd = cmd[28] ? (cmd[27:26] == 2'b10) : cmd[27];
    last_cap = (edge_cfg != 0) ? 128 * h + lat_cfg : 127 * h + lat_cfg;
    end_e = 128 * h;
    if (rd && last_cap > end_e) end_e = last_cap;
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 3'd0; bus_wdata = cmd; mdio_i = pat(0, seed);
    for (int k = 0; k <= end_e + 3; k++) begin
      logic [3:0] exp, act;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_addr = 3'd0;
      #1;
      exp = '0;
      exp[3] = (k < end_e);
      if (k < 128 * h) begin
        int b;
        b = k / (2 * h);
        exp[2] = ((k / h) % 2) == 1;
        exp[1] = !(rd && b >= 46);
        exp[0] = exp[1] && fbit(cmd, b, rd);
      end
      act = {bus_rdata[31], mdc, mdio_oe, mdio_o};
      check("R2 R3 R4 R5 R6 R7 per-cycle busy/mdc/oe/mdo", 32'(act), 32'(exp));
      if (rd && is_cap(k + 1, h)) samples.push_back(pat(k + 1, seed));
      mdio_i = pat(k + 1, seed);
      if (poke && k == 20) begin
        bus_wr_en = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h8FFF_FFFF;
      end
      if (poke && k == 21) begin
        bus_wr_en = 1'b1; bus_addr = 3'd4; bus_wdata = 32'hFFF0_0000;
      end
    end
    rd_reg(3'd4, v);
    check("R2 idle after frame", 32'(v[16]), 32'd1);
    if (rd) begin
      exp_rd = '0;
      foreach (samples[i]) exp_rd = {exp_rd[14:0], samples[i]};
      check("R6 R7 read result", 32'(v[15:0]), 32'(exp_rd));
    end
    bus_addr = 3'd0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] cmd_a;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = 3'd0; bus_wdata = '0; mdio_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd_reg(3'd0, v); check("R1 command reset", v, 32'h0000_0000);
    rd_reg(3'd4, v); check("R1 status reset", v, 32'h0401_0000);
    check("R1 mdc/oe reset", {30'd0, mdc, mdio_oe}, 32'd0);

    set_cfg(1, 0, 0);
    rd_reg(3'd4, v); check("R9 status layout", v, 32'h0101_0000);

    // Clause 22 write, with register writes thrown at it mid-frame
    cmd_a = 32'h8000_0000 | (32'd1 << 28) | (32'd1 << 26) | (32'h13 << 21) | (32'h0A << 16) | 32'hA5C3;
    run_frame(cmd_a, 0, 1'b1);
    rd_reg(3'd0, v); check("R8 R9 command held", v, {3'b000, cmd_a[28:0]});
    rd_reg(3'd4, v); check("R8 config held", {v[31:20], 20'h0}, 32'h0100_0000);

    // Clause 22 read, rising edge, no delay
    run_frame(32'h8000_0000 | (32'd1 << 28) | (32'd2 << 26) | (32'h01 << 21) | (32'h02 << 16), 1, 1'b0);

    // Clause 45 address frame with the fastest divider
    set_cfg(0, 0, 0);
    run_frame(32'h8000_0000 | (32'd0 << 26) | (32'h03 << 21) | (32'h01 << 16) | 32'h1234, 0, 1'b0);

    // Clause 45 read, falling edge, two-clock delay
    set_cfg(2, 1, 2);
    run_frame(32'h8000_0000 | (32'd3 << 26) | (32'h07 << 21) | (32'h03 << 16), 3, 1'b0);

    // Clause 45 read with post-increment, rising edge, three-clock delay
    set_cfg(1, 0, 3);
    run_frame(32'h8000_0000 | (32'd2 << 26) | (32'h1F << 21) | (32'h1F << 16) | 32'hFFFF, 5, 1'b0);

    // R10: fields stored without a launch
    wr_reg(3'd0, 32'h1ABC_5678);
    for (int i = 0; i < 6; i++) begin
      rd_reg(3'd0, v);
      check("R10 no launch", {29'd0, v[31], mdc, mdio_oe}, 32'd0);
      @(negedge clk);
    end
    rd_reg(3'd0, v); check("R10 R9 fields stored", v, 32'h1ABC_5678);

    finish_tb();
  end

endmodule